// File: doc/BRIEF.md
# DMA Channel Request Arbiter with Per-Pair Address Modes

The block decides which DMA channel owns the next transfer. Four request positions sit in two channel pairs. Each pair has its own mode bit. In split mode the pair offers two independent sub-channels, A and B. In joined mode the pair's two request lines are folded into one request, which ranks at the pair's A position.

A fixed priority chooses among the pending requests. The grant is registered and one-hot, and it changes only at bus-release points. A burst holds the grant until the owning channel stops requesting. A block transfer holds the grant until the end-of-block indication. A single transfer gives up the grant at every release.

Requests are level inputs. They are captured only in cycles where the sampling enable is high, so the surrounding controller decides when sampling resumes, for example one state into a buffered write. Arbitration always works on the last captured request vector.

Top module: `dma_chan_arb`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `grant_o` is all zeros.
- R2: Position order is bit 0 = pair 0 A, bit 1 = pair 0 B, bit 2 = pair 1 A, bit 3 = pair 1 B. With both pairs in split mode (`full_mode_i` bit = 0), an arbitration grants the lowest-numbered requesting position.
- R3: With a pair in joined mode (`full_mode_i[p]` = 1), a request on either of that pair's bits is granted at its A bit (2p), and its B bit (2p+1) is never granted by an arbitration.
- R4: Each pair's mode applies to that pair alone. With pair 1 joined and pair 0 split, pair 0's B request still wins over a request on bit 3.
- R5: `grant_o` changes only in the cycle after an edge where `bus_rel_i` was high. At any other time it holds its value.
- R6: An arbitration with no sampled request drives `grant_o` to all zeros.
- R7: Requests are captured on edges where `smp_en_i` is high, and the captured vector is held otherwise. A request that is deasserted and then sampled before the next release is not granted.
- R8: Transfer type is 2'b00 single, 2'b01 burst, 2'b10 block, and 2'b11 is treated as single. The type is taken at the granting release. A burst grant is kept across a release while the granted position still has a sampled request. The release after that request drops re-arbitrates.
- R9: A block grant is kept across every release where `blk_end_i` is low. A release with `blk_end_i` high re-arbitrates.
- R10: A single-type grant is re-arbitrated at every release, so a higher-priority request takes the grant at the next release.
- R11: `grant_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Level requests, one per sub-channel position |
| full_mode_i | input | 2 | Per-pair mode, 1 = joined (full address), 0 = split |
| smp_en_i | input | 1 | Request capture enable |
| bus_rel_i | input | 1 | Bus-release strobe; arbitration point |
| xfer_type_i | input | 2 | Transfer type of the channel being granted |
| blk_end_i | input | 1 | End of the current block, taken at a release |
| grant_o | output | 4 | One-hot grant, zero when idle |

## Verification
The assertions assume three things about the inputs. The mode bits are stable around an arbitration. `blk_end_i` only has meaning together with `bus_rel_i`. The transfer type is valid in the cycle of the granting release. The stimulus keeps to this by changing inputs one time unit after a rising edge. It also changes modes only right after a reset, and it raises the end-of-block flag only in release cycles. Each scenario loads requests in sampling cycles that are kept apart from release cycles. This way the captured vector that an arbitration uses is known exactly.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    XFER_SINGLE = 2'b00,
    XFER_BURST  = 2'b01,
    XFER_BLOCK  = 2'b10,
    XFER_RSVD   = 2'b11
  } xfer_e;
endpackage

// File: rtl/dma_req_merge.sv
module dma_req_merge #(
  parameter int NUM_PAIRS = 2,
  localparam int NCH = 2 * NUM_PAIRS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic             smp_en_i,
  input  logic [NUM_PAIRS-1:0] full_mode_i,
  output logic [NCH-1:0]   req_q_o,
  output logic [NCH-1:0]   eff_o
);
  logic [NCH-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= '0;
    else if (smp_en_i) req_q <= req_i;
  end

  // joined pair folds B onto A
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign eff_o[2*p]   = full_mode_i[p] ? (req_q[2*p] | req_q[2*p+1]) : req_q[2*p];
    assign eff_o[2*p+1] = full_mode_i[p] ? 1'b0 : req_q[2*p+1];
  end

  assign req_q_o = req_q;
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] pick_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_rel_i,
  input  logic [1:0]     xfer_type_i,
  input  logic           blk_end_i,
  input  logic [NCH-1:0] eff_i,
  input  logic [NCH-1:0] pick_i,
  output logic [NCH-1:0] grant_o,
  output logic           lock_o,
  output logic           burst_o
);
  logic [NCH-1:0] grant_q;
  logic           lock_q, burst_q, hold;
  xfer_e          typ;

  assign typ  = xfer_e'(xfer_type_i);
  assign hold = lock_q && (burst_q ? |(eff_i & grant_q) : !blk_end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      lock_q  <= 1'b0;
      burst_q <= 1'b0;
    end else if (bus_rel_i && !hold) begin
      grant_q <= pick_i;
      lock_q  <= (|pick_i) && (typ == XFER_BURST || typ == XFER_BLOCK);
      burst_q <= (typ == XFER_BURST);
    end
  end

  assign grant_o = grant_q;
  assign lock_o  = lock_q;
  assign burst_o = burst_q;
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
  parameter int NUM_PAIRS = 2,
  localparam int NCH = 2 * NUM_PAIRS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       req_i,
  input  logic [NUM_PAIRS-1:0] full_mode_i,
  input  logic                 smp_en_i,
  input  logic                 bus_rel_i,
  input  logic [1:0]           xfer_type_i,
  input  logic                 blk_end_i,
  output logic [NCH-1:0]       grant_o
);
  logic [NCH-1:0] req_q_w, eff_w, pick_w;
  logic           lock_w, burst_w;

  dma_req_merge #(.NUM_PAIRS(NUM_PAIRS)) u_merge (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .smp_en_i(smp_en_i),
    .full_mode_i(full_mode_i), .req_q_o(req_q_w), .eff_o(eff_w)
  );

  dma_prio_pick #(.NCH(NCH)) u_pick (.req_i(eff_w), .pick_o(pick_w));

  dma_grant_ctrl #(.NCH(NCH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_rel_i(bus_rel_i),
    .xfer_type_i(xfer_type_i), .blk_end_i(blk_end_i), .eff_i(eff_w),
    .pick_i(pick_w), .grant_o(grant_o), .lock_o(lock_w), .burst_o(burst_w)
  );
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
  parameter int NUM_PAIRS = 2,
  localparam int NCH = 2 * NUM_PAIRS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PAIRS-1:0] full_mode_i,
  input logic                 bus_rel_i,
  input logic                 blk_end_i,
  input logic [NCH-1:0]       eff_w,
  input logic                 lock_w,
  input logic                 burst_w,
  input logic [NCH-1:0]       grant_o
);
  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  a_r5_hold_no_rel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rel_i |=> $stable(grant_o));

  a_r2_top_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rel_i && !lock_w && eff_w[0] |=> grant_o[0]);

  a_r3_no_b_joined: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rel_i && !lock_w && full_mode_i[0] |=> !grant_o[1]);

  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rel_i && !lock_w && (eff_w == '0) |=> (grant_o == '0));

  a_r8_burst_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rel_i && lock_w && burst_w && |(eff_w & grant_o) |=> $stable(grant_o));

  a_r9_block_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rel_i && lock_w && !burst_w && !blk_end_i |=> $stable(grant_o));
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_mode_i(full_mode_i),
  .bus_rel_i(bus_rel_i), .blk_end_i(blk_end_i), .eff_w(eff_w),
  .lock_w(lock_w), .burst_w(burst_w), .grant_o(grant_o)
);

// File: tb/dma_chan_arb_tb.sv
module dma_chan_arb_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [1:0] full_mode_i = '0;
  logic       smp_en_i = 1'b0;
  logic       bus_rel_i = 1'b0;
  logic [1:0] xfer_type_i = '0;
  logic       blk_end_i = 1'b0;
  logic [3:0] grant_o;
  int checks = 0, errors = 0;

  localparam logic [1:0] SGL = 2'b00, BST = 2'b01, BLK = 2'b10;

  dma_chan_arb u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if (grant_o !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant_o, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_ni = 1'b0; req_i = '0; smp_en_i = 0; bus_rel_i = 0; blk_end_i = 0;
    full_mode_i = mode;
    step(); step();
    chk("R1 in reset", 4'b0000);
    rst_ni = 1'b1;
    step();
    chk("R1 after reset", 4'b0000);
  endtask

  task automatic load(input logic [3:0] r);
    req_i = r; smp_en_i = 1'b1; step(); smp_en_i = 1'b0;
  endtask

  task automatic rel(input logic [1:0] t, input logic be);
    bus_rel_i = 1'b1; xfer_type_i = t; blk_end_i = be;
    step();
    bus_rel_i = 1'b0; blk_end_i = 1'b0;
  endtask

  task automatic t_short_prio();
    do_reset(2'b00);
    load(4'b1111); rel(SGL, 0); chk("R2 all", 4'b0001);
    load(4'b1110); rel(SGL, 0); chk("R2 0B", 4'b0010);
    load(4'b1100); rel(SGL, 0); chk("R2 1A", 4'b0100);
    load(4'b1000); rel(SGL, 0); chk("R2 1B", 4'b1000);
  endtask

  task automatic t_full_mode();
    do_reset(2'b01);
    load(4'b0010); rel(SGL, 0); chk("R3 B folds to A", 4'b0001);
    load(4'b1010); rel(SGL, 0); chk("R3 pair0 over 1B", 4'b0001);
    do_reset(2'b10);
    load(4'b1000); rel(SGL, 0); chk("R4 pair1 joined", 4'b0100);
    load(4'b1010); rel(SGL, 0); chk("R4 0B split wins", 4'b0010);
  endtask

  task automatic t_idle_and_sample();
    do_reset(2'b00);
    load(4'b0000); rel(SGL, 0); chk("R6 no request", 4'b0000);
    req_i = 4'b0001; step(); rel(SGL, 0); chk("R7 unsampled", 4'b0000);
    load(4'b0100); req_i = 4'b0000; step(); rel(SGL, 0); chk("R7 held sample", 4'b0100);
    load(4'b0001); load(4'b0000); rel(SGL, 0); chk("R7 dropped", 4'b0000);
  endtask

  task automatic t_stable_single();
    do_reset(2'b00);
    load(4'b1000); rel(SGL, 0); chk("R10 initial", 4'b1000);
    load(4'b1001); step(); step(); chk("R5 no release", 4'b1000);
    rel(SGL, 0); chk("R10 preempt", 4'b0001);
    rel(2'b11, 0); chk("R8 rsvd as single", 4'b0001);
  endtask

  task automatic t_burst();
    do_reset(2'b00);
    load(4'b0100); rel(BST, 0); chk("R8 start", 4'b0100);
    load(4'b0101); rel(SGL, 0); chk("R8 held", 4'b0100);
    load(4'b0001); rel(SGL, 0); chk("R8 released", 4'b0001);
  endtask

  task automatic t_block();
    do_reset(2'b00);
    load(4'b1000); rel(BLK, 0); chk("R9 start", 4'b1000);
    load(4'b1001); rel(SGL, 0); chk("R9 held", 4'b1000);
    rel(SGL, 0); chk("R9 held again", 4'b1000);
    rel(SGL, 1); chk("R9 end rearb", 4'b0001);
  endtask

  initial begin
    t_short_prio();
    t_full_mode();
    t_idle_and_sample();
    t_stable_single();
    t_burst();
    t_block();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule